// File: doc/BRIEF.md
# Dirty Victim Write-Back Buffer

When a cache miss forces a modified line out of the cache, this block takes the whole line in one transfer: eight 32-bit words plus the line-aligned physical address of where the line belongs. It keeps the line while the cache fetches the replacement line, so refill reads have the external bus to themselves. It starts writing the saved line to memory only after the miss controller signals that the refill is complete.

The drain issues one word write per memory handshake, lowest word first. Each write stays on the bus until the memory side acknowledges it. While a line is held or being drained, the buffer reports busy and refuses new loads. The miss controller must stall any further eviction until the final acknowledgement has returned the buffer to empty.

Top module: `victim_wbuf`

## Requirements
- R1: After reset the buffer is empty: `empty`=1, `busy`=0, `ld_ready`=1, `mem_req`=0.
- R2: A load (`ld_req`=1 while `ld_ready`=1) is captured at that clock edge. From the next cycle `busy`=1, `empty`=0 and `ld_ready`=0.
- R3: A load request made while `busy`=1 is refused (`ld_ready`=0) and leaves the stored line and address unchanged, which the following drain shows.
- R4: While a line is held and `drain_en` is low, no memory write is issued (`mem_req`=0), however long the wait.
- R5: The first edge at which a held line sees `drain_en`=1 starts the drain: `mem_req` rises in the next cycle, presenting word 0. Once started, the drain continues regardless of `drain_en`.
- R6: Word i (i = 0..7, taken from `ld_line[32*i +: 32]`) is written to address {`ld_tag`, i[2:0], 2'b00}, in increasing order of i.
- R7: While `mem_req`=1 and `mem_ack`=0, `mem_req`, `mem_addr` and `mem_wdata` hold their values into the next cycle.
- R8: The cycle after the acknowledgement of word 7, `mem_req`=0, `busy`=0, `empty`=1 and `ld_ready`=1.
- R9: `drain_en` while the buffer is empty has no effect: `mem_req` stays 0.
- R10: A load held high across the final acknowledgement is accepted at the very next edge, so a new line can follow with no idle cycle beyond the empty one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ld_req | input | 1 | Miss controller offers an evicted dirty line |
| ld_ready | output | 1 | Buffer can take a line this cycle |
| ld_tag | input | 24 | Physical address bits [28:5] of the evicted line |
| ld_line | input | 256 | Line data, word i in bits [32*i+31:32*i] |
| drain_en | input | 1 | Refill of the replacement line has completed |
| busy | output | 1 | A line is held or being drained |
| empty | output | 1 | No line is held |
| mem_req | output | 1 | Word write request to external memory |
| mem_addr | output | 29 | Physical byte address of the word being written |
| mem_wdata | output | 32 | Data of the word being written |
| mem_ack | input | 1 | Memory accepts the current word at this edge |

## Verification
Every result is due one edge after the stimulus that causes it. Status changes one cycle after an accepted load. The first write appears one cycle after `drain_en` is seen with a line held, and each next word one cycle after an acknowledgement. The buffer is empty one cycle after the eighth acknowledgement. Stimulus is driven on the falling edge and outputs are checked on the following falling edge. The bench advances its model of the current word index only on the cycles in which it drives `mem_ack`, so each check compares against the value that should be present after exactly one register stage. Random acknowledgement delays and random hold times before `drain_en` exercise the waiting cases, in which the outputs must not move.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

  typedef enum logic [1:0] {
    WB_EMPTY = 2'd0,
    WB_HOLD  = 2'd1,
    WB_DRAIN = 2'd2
  } wb_state_e;

endpackage

// File: rtl/wbuf_store.sv
module wbuf_store #(
  parameter int WORDS  = 8,
  parameter int WORD_W = 32,
  parameter int TAG_W  = 24,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [TAG_W-1:0]        tag_in,
  input  logic [WORDS*WORD_W-1:0] line_in,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic [TAG_W-1:0]        tag_q,
  output logic [WORD_W-1:0]       rd_word
);

  logic [WORD_W-1:0] word_q [WORDS];
  logic [TAG_W-1:0]  tag_d;

  always_comb begin
    tag_d = tag_q;
    if (wr_en) tag_d = tag_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tag_q <= '0;
    else        tag_q <= tag_d;
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [WORD_W-1:0] word_d;

    always_comb begin
      word_d = word_q[g];
      if (wr_en) word_d = line_in[g*WORD_W +: WORD_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q[g] <= '0;
      else        word_q[g] <= word_d;
    end
  end

  assign rd_word = word_q[rd_idx];

  // R3
  held_line_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(tag_q));

endmodule

// File: rtl/wbuf_ctrl.sv
module wbuf_ctrl
  import wbuf_pkg::*;
#(
  parameter int WORDS = 8,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_req,
  input  logic             drain_en,
  input  logic             mem_ack,
  output logic             load_en,
  output logic [IDX_W-1:0] idx,
  output wb_state_e        state
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

  wb_state_e        state_d;
  logic [IDX_W-1:0] idx_d;
  logic             last_word;
  logic             word_done;

  assign last_word = (idx == LAST_IDX);
  assign word_done = (state == WB_DRAIN) && mem_ack;
  assign load_en   = (state == WB_EMPTY) && ld_req;

  always_comb begin
    state_d = state;
    unique case (state)
      WB_EMPTY: if (ld_req)                 state_d = WB_HOLD;
      WB_HOLD:  if (drain_en)               state_d = WB_DRAIN;
      WB_DRAIN: if (word_done && last_word) state_d = WB_EMPTY;
      default:                              state_d = WB_EMPTY;
    endcase
  end

  always_comb begin
    idx_d = idx;
    if (load_en)        idx_d = '0;
    else if (word_done) idx_d = last_word ? '0 : idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= WB_EMPTY;
      idx   <= '0;
    end else begin
      state <= state_d;
      idx   <= idx_d;
    end
  end

  // R8
  last_ack_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WB_DRAIN && mem_ack && idx == LAST_IDX) |=> (state == WB_EMPTY));

  // R4
  hold_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WB_HOLD && !drain_en) |=> (state == WB_HOLD));

endmodule

// File: rtl/victim_wbuf.sv
module victim_wbuf
  import wbuf_pkg::*;
#(
  parameter int WORDS  = 8,
  parameter int WORD_W = 32,
  parameter int PA_W   = 29,
  localparam int IDX_W    = $clog2(WORDS),
  localparam int BYTE_OFS = $clog2(WORD_W / 8),
  localparam int LINE_LSB = IDX_W + BYTE_OFS,
  localparam int TAG_W    = PA_W - LINE_LSB
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ld_req,
  output logic                    ld_ready,
  input  logic [TAG_W-1:0]        ld_tag,
  input  logic [WORDS*WORD_W-1:0] ld_line,
  input  logic                    drain_en,
  output logic                    busy,
  output logic                    empty,
  output logic                    mem_req,
  output logic [PA_W-1:0]         mem_addr,
  output logic [WORD_W-1:0]       mem_wdata,
  input  logic                    mem_ack
);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             load_en;
  logic [IDX_W-1:0] idx;
  wb_state_e        state;
  logic [TAG_W-1:0] tag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  wbuf_ctrl #(.WORDS(WORDS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ld_req   (ld_req),
    .drain_en (drain_en),
    .mem_ack  (mem_ack),
    .load_en  (load_en),
    .idx      (idx),
    .state    (state)
  );

  wbuf_store #(.WORDS(WORDS), .WORD_W(WORD_W), .TAG_W(TAG_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (load_en),
    .tag_in  (ld_tag),
    .line_in (ld_line),
    .rd_idx  (idx),
    .tag_q   (tag_q),
    .rd_word (mem_wdata)
  );

  assign empty    = (state == WB_EMPTY);
  assign busy     = !empty;
  assign ld_ready = empty;
  assign mem_req  = (state == WB_DRAIN);
  assign mem_addr = {tag_q, idx, BYTE_OFS'(0)};

  // R2
  load_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ld_req && ld_ready) |=> (busy && !ld_ready));

  // R5
  drain_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(mem_req) |-> $past(drain_en));

  // R7
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));

  // R6
  word_order_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mem_req && mem_ack && mem_addr[LINE_LSB-1:BYTE_OFS] != IDX_W'(WORDS - 1))
      |=> (mem_req && mem_addr[LINE_LSB-1:BYTE_OFS] == $past(mem_addr[LINE_LSB-1:BYTE_OFS]) + 1'b1));

  // R9
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (empty && !ld_req) |=> !mem_req);

endmodule

// File: tb/victim_wbuf_test.sv
module victim_wbuf_test;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int WORDS = 8;
  localparam int WW    = 32;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           ld_req;
  logic           ld_ready;
  logic [23:0]    ld_tag;
  logic [255:0]   ld_line;
  logic           drain_en;
  logic           busy;
  logic           empty;
  logic           mem_req;
  logic [28:0]    mem_addr;
  logic [31:0]    mem_wdata;
  logic           mem_ack;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  victim_wbuf uut (
    .clk(clk), .rst_n(rst_n), .ld_req(ld_req), .ld_ready(ld_ready),
    .ld_tag(ld_tag), .ld_line(ld_line), .drain_en(drain_en),
    .busy(busy), .empty(empty), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack)
  );

  function automatic logic [28:0] exp_addr(logic [23:0] tag, int i);
    return {tag, i[2:0], 2'b00};
  endfunction

  function automatic logic [31:0] exp_word(logic [255:0] line, int i);
    return line[i*WW +: WW];
  endfunction

  function automatic logic [255:0] rand_line();
    logic [255:0] l;
    for (int k = 0; k < WORDS; k++) l[k*WW +: WW] = $urandom;
    return l;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  // Load a line; ld_req must be low when called.
  task automatic do_load(logic [23:0] tag, logic [255:0] line);
    ld_req = 1; ld_tag = tag; ld_line = line;
    @(negedge clk);
    ld_req = 0;
    chk(busy && !empty && !ld_ready, "R2 status after load",
        {61'b0, busy, empty, ld_ready}, 64'b100);
  endtask

  // Hold for wait_n cycles (optionally poking a refused load), then drain.
  task automatic hold_and_drain(logic [23:0] tag, logic [255:0] line,
                                int wait_n, bit poke, bit chain,
                                logic [23:0] ntag, logic [255:0] nline);
    for (int c = 0; c < wait_n; c++) begin
      if (poke && c == 0) begin
        ld_req = 1; ld_tag = ~tag; ld_line = ~line;
      end
      @(negedge clk);
      ld_req = 0;
      chk(!mem_req && busy, "R4 no write while held",
          {62'b0, mem_req, busy}, 64'b01);
      if (poke && c == 0)
        chk(!ld_ready, "R3 load refused while busy", {63'b0, ld_ready}, 64'b0);
    end
    drain_en = 1;
    @(negedge clk);
    drain_en = 0;
    chk(mem_req === 1'b1, "R5 drain starts", {63'b0, mem_req}, 64'b1);
    for (int i = 0; i < WORDS; i++) begin
      int d;
      d = $urandom_range(0, 3);
      if (i == 0 && (tag[0])) drain_en = 1;   // enable again mid-drain: harmless
      for (int w = 0; w < d; w++) begin
        chk(mem_req && mem_addr == exp_addr(tag, i), "R6 address",
            {35'b0, mem_addr}, {35'b0, exp_addr(tag, i)});
        chk(mem_wdata == exp_word(line, i), "R6 data",
            {32'b0, mem_wdata}, {32'b0, exp_word(line, i)});
        @(negedge clk);
        drain_en = 0;
        chk(mem_req && mem_addr == exp_addr(tag, i) && mem_wdata == exp_word(line, i),
            "R7 held until ack", {3'b0, mem_addr, mem_wdata}, {3'b0, exp_addr(tag, i), exp_word(line, i)});
      end
      chk(mem_req && mem_addr == exp_addr(tag, i), "R6 address",
          {35'b0, mem_addr}, {35'b0, exp_addr(tag, i)});
      chk(mem_wdata == exp_word(line, i), "R6 data",
          {32'b0, mem_wdata}, {32'b0, exp_word(line, i)});
      mem_ack = 1;
      if (chain && i == WORDS - 1) begin
        ld_req = 1; ld_tag = ntag; ld_line = nline;
      end
      @(negedge clk);
      mem_ack = 0;
      drain_en = 0;
    end
    chk(!mem_req && !busy && empty && ld_ready, "R8 empty after last ack",
        {60'b0, mem_req, busy, empty, ld_ready}, 64'b0011);
    if (chain) begin
      @(negedge clk);
      ld_req = 0;
      chk(busy && !empty, "R10 back-to-back load", {62'b0, busy, empty}, 64'b10);
    end
  endtask

  initial begin
    #1_000_000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [23:0]  tag, ntag;
    logic [255:0] line, nline;
    bit           chained;
    void'($urandom(32'd20240611));
    rst_n = 0; ld_req = 0; ld_tag = '0; ld_line = '0; drain_en = 0; mem_ack = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(empty && !busy && ld_ready && !mem_req, "R1 reset state",
        {60'b0, empty, busy, ld_ready, mem_req}, 64'b1010);

    drain_en = 1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(!mem_req && empty, "R9 drain_en while empty",
          {62'b0, mem_req, empty}, 64'b01);
    end
    drain_en = 0;

    // Directed: all-ones tag, immediate drain, no poke
    tag = 24'hFFFFFF; line = rand_line();
    do_load(tag, line);
    hold_and_drain(tag, line, 0, 0, 0, '0, '0);

    // Directed: zero tag, long hold with refused load
    tag = 24'h000000; line = rand_line();
    do_load(tag, line);
    hold_and_drain(tag, line, 12, 1, 0, '0, '0);

    chained = 0;
    for (int r = 0; r < 25; r++) begin
      if (!chained) begin
        tag = $urandom; line = rand_line();
        do_load(tag, line);
      end
      ntag = $urandom; nline = rand_line();
      chained = ($urandom_range(0, 2) == 0);
      hold_and_drain(tag, line, $urandom_range(0, 6), $urandom_range(0, 1),
                     chained, ntag, nline);
      if (chained) begin
        tag = ntag; line = nline;
      end
    end
    if (chained) hold_and_drain(tag, line, 1, 0, 0, '0, '0);

    repeat (2) @(negedge clk);
    report();
  end

endmodule